// File: doc/BRIEF.md
# Lockable GPIO Bank Register File

This block is one bank of general-purpose pins seen through a small 32-bit register bus. Software chooses for each pin whether it drives or listens, raises or lowers driven pins through separate set and clear strobes, and reads back both the levels it drives and the levels it sees on the pads. Pad levels are brought into the clock domain through a synchronizer chain before software can see them.

A per-pin lock mask protects pins from stray writes. The mask itself is guarded by a key: a write to the lock register only lands when the bus write just before it put the unlock key `0x00A5A501` into the key register. Any other write in between disarms the key. Pins whose lock bit is set ignore writes to their control word and to their set and clear bits. The bank leaves reset with every pin an input, every output low and every pin locked.

The bus is a plain strobe interface. A write completes in the cycle `bus_wr` is sampled. A read returns its data on `bus_rdata` in the cycle after `bus_rd` is sampled, and `bus_rdata` holds that value until the next read. Word addresses (6 bits) are: 0x00 driven levels (read), 0x01 synchronized pad levels (read), 0x02 set strobe (write), 0x03 clear strobe (write), 0x05 key (write), 0x06 lock mask (read/write), 0x20+p control word of pin p, whose bit 0 is the direction.

Top module: `gpio_lock_bank`

## Requirements
- R1: After reset every control word reads 1 (input), the driven levels read 0, `pad_out` and `pad_oe` are all 0, and the lock mask reads all ones.
- R2: A write to the control word at 0x20+p sets pin p's direction from data bit 0 (1 = input, 0 = output). The word reads back the direction in bit 0, and `pad_oe[p]` is high exactly when pin p is an output.
- R3: A write to 0x02 drives high every pin whose data bit is 1; a write to 0x03 drives low every pin whose data bit is 1; bits written as 0 leave their pins unchanged. The output latch updates whatever the pin's direction.
- R4: A read of 0x00 returns the driven levels, which equal `pad_out`.
- R5: A read of 0x01 returns `pad_in` through a two-flop synchronizer: a pad change applied before clock edge k is captured by a read sampled at edge k+2 or later, and not by a read sampled at edge k+1.
- R6: A write to 0x06 replaces the lock mask (bit p locks pin p) only when the preceding bus write was `0x00A5A501` to 0x05; otherwise it is discarded.
- R7: Any bus write other than the correct key to 0x05 disarms the key, including a wrong key value and the lock write that used it; reads do not disarm it, and repeating the correct key keeps it armed.
- R8: While a pin's lock bit is 1, writes to its control word and its set and clear bits have no effect; unlocked pins hit by the same write still update.
- R9: Reads of write-only or unmapped addresses (0x02, 0x03, 0x05, 0x04, 0x07 to 0x1F) return 0.
- R10: A read of 0x06 returns the current lock mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| pad_in | input | NPINS | Asynchronous pad levels |
| pad_out | output | NPINS | Driven output levels |
| pad_oe | output | NPINS | Output enable per pin, high for outputs |

## Verification
The bench builds the bank with its defaults, 32 pins and a two-stage synchronizer, so the lock mask spans the full bus word and a single write can split across locked and unlocked pins at the 16-bit boundary. With two stages the exact read cycle in which a pad change first shows is fixed and checked on both sides. The key sequencing is driven through every disarming path: an unarmed lock write, a write slipped in between, a wrong key, a consumed key, reads in between and a repeated key.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned IDX_W  = 5;

  localparam logic [ADDR_W-1:0] ADR_DRIVEN = 6'h00;
  localparam logic [ADDR_W-1:0] ADR_PADS   = 6'h01;
  localparam logic [ADDR_W-1:0] ADR_SET    = 6'h02;
  localparam logic [ADDR_W-1:0] ADR_CLR    = 6'h03;
  localparam logic [ADDR_W-1:0] ADR_KEY    = 6'h05;
  localparam logic [ADDR_W-1:0] ADR_LOCK   = 6'h06;

  localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h00A5_A501;
endpackage

// File: rtl/gpio_key_guard.sv
module gpio_key_guard
  import gpio_lock_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [NPINS-1:0]  lock_q,
  output logic              armed_q
);
  logic key_ok;
  logic lock_hit;

  assign key_ok   = (addr == ADR_KEY) && (wdata == UNLOCK_KEY);
  assign lock_hit = (addr == ADR_LOCK);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      lock_q  <= '1;
    end else if (wr_en) begin
      if (lock_hit && armed_q) lock_q <= wdata[NPINS-1:0];
      armed_q <= key_ok;
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_sync
);
  logic [NPINS-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= pad_in;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign pad_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_lock_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [NPINS-1:0]  lock_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  out_q
);
  logic set_wr;
  logic clr_wr;
  logic ctl_wr;

  assign set_wr = wr_en && (addr == ADR_SET);
  assign clr_wr = wr_en && (addr == ADR_CLR);
  assign ctl_wr = wr_en && addr[ADDR_W-1];

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic dir_r;
    logic out_r;
    logic ctl_hit;

    assign ctl_hit = ctl_wr && (addr[IDX_W-1:0] == IDX_W'(p));

    always_ff @(posedge clk) begin
      if (rst) begin
        dir_r <= 1'b1;
        out_r <= 1'b0;
      end else if (!lock_q[p]) begin
        if (ctl_hit) dir_r <= wdata[0];
        if (set_wr && wdata[p]) out_r <= 1'b1;
        else if (clr_wr && wdata[p]) out_r <= 1'b0;
      end
    end

    assign dir_q[p] = dir_r;
    assign out_q[p] = out_r;
  end
endmodule

// File: rtl/gpio_lock_bank.sv
module gpio_lock_bank
  import gpio_lock_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [5:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);
  logic [NPINS-1:0] lock_q;
  logic             armed_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] out_q;
  logic [NPINS-1:0] pad_sync;
  logic [BUS_W-1:0] dir_word;
  logic [BUS_W-1:0] rd_mux;

  gpio_key_guard #(.NPINS(NPINS)) u_guard (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .lock_q(lock_q), .armed_q(armed_q)
  );

  gpio_pin_ctrl #(.NPINS(NPINS)) u_pins (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .lock_q(lock_q), .dir_q(dir_q), .out_q(out_q)
  );

  gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pad_in(pad_in), .pad_sync(pad_sync)
  );

  assign dir_word = BUS_W'(dir_q);

  always_comb begin
    rd_mux = '0;
    if (bus_addr[ADDR_W-1]) begin
      rd_mux[0] = dir_word[bus_addr[IDX_W-1:0]];
    end else begin
      case (bus_addr)
        ADR_DRIVEN: rd_mux = BUS_W'(out_q);
        ADR_PADS:   rd_mux = BUS_W'(pad_sync);
        ADR_LOCK:   rd_mux = BUS_W'(lock_q);
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign pad_out = out_q;
  assign pad_oe  = ~dir_q;
endmodule

// File: rtl/gpio_lock_bank_chk.sv
module gpio_lock_bank_chk
  import gpio_lock_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [5:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic [NPINS-1:0] lock_q,
  input logic             armed_q,
  input logic [NPINS-1:0] dir_q,
  input logic [NPINS-1:0] out_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (out_q == '0 && (&lock_q) && (&dir_q) && !armed_q));

  // R6
  unarmed_lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADR_LOCK && !armed_q) |=> $stable(lock_q));

  // R6
  armed_lock_take_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADR_LOCK && armed_q) |=> lock_q == $past(bus_wdata[NPINS-1:0]));

  // R7
  disarm_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !(bus_addr == ADR_KEY && bus_wdata == UNLOCK_KEY)) |=> !armed_q);

  // R8
  locked_out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((out_q ^ $past(out_q)) & $past(lock_q)) == '0);

  // R8
  locked_dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((dir_q ^ $past(dir_q)) & $past(lock_q)) == '0);

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 6'h07) |=> bus_rdata == '0);
endmodule

bind gpio_lock_bank gpio_lock_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_q(lock_q),
  .armed_q(armed_q), .dir_q(dir_q), .out_q(out_q)
);

// File: tb/gpio_lock_bank_bench.sv
module gpio_lock_bank_bench;
  localparam int NPINS = 32;
  localparam int NV    = 40;
  // entry: {req[3:0], op[3:0] (0 write, 1 read-check), addr[7:0], data[31:0], expect[31:0]}
  localparam logic [79:0] VEC [NV] = '{
    {4'd1,  4'h1, 8'h20, 32'h0, 32'h0000_0001},  // R1 pin 0 input
    {4'd1,  4'h1, 8'h00, 32'h0, 32'h0000_0000},  // R1 outputs low
    {4'd10, 4'h1, 8'h06, 32'h0, 32'hFFFF_FFFF},  // R10 all locked
    {4'd8,  4'h0, 8'h02, 32'hFFFF_FFFF, 32'h0},
    {4'd8,  4'h1, 8'h00, 32'h0, 32'h0000_0000},  // R8 locked set ignored
    {4'd6,  4'h0, 8'h06, 32'h0, 32'h0},
    {4'd6,  4'h1, 8'h06, 32'h0, 32'hFFFF_FFFF},  // R6 unarmed write dropped
    {4'd6,  4'h0, 8'h05, 32'h00A5_A501, 32'h0},
    {4'd6,  4'h0, 8'h06, 32'hFFFF_0000, 32'h0},
    {4'd6,  4'h1, 8'h06, 32'h0, 32'hFFFF_0000},  // R6 armed write lands
    {4'd7,  4'h0, 8'h06, 32'h0, 32'h0},
    {4'd7,  4'h1, 8'h06, 32'h0, 32'hFFFF_0000},  // R7 key consumed
    {4'd3,  4'h0, 8'h02, 32'hFFFF_FFFF, 32'h0},
    {4'd3,  4'h1, 8'h00, 32'h0, 32'h0000_FFFF},  // R3 R8 split set
    {4'd3,  4'h0, 8'h03, 32'h0000_000F, 32'h0},
    {4'd3,  4'h1, 8'h00, 32'h0, 32'h0000_FFF0},  // R3 clear
    {4'd2,  4'h0, 8'h23, 32'hFFFF_FFFE, 32'h0},
    {4'd2,  4'h1, 8'h23, 32'h0, 32'h0000_0000},  // R2 pin 3 output
    {4'd8,  4'h0, 8'h30, 32'h0, 32'h0},
    {4'd8,  4'h1, 8'h30, 32'h0, 32'h0000_0001},  // R8 locked ctrl ignored
    {4'd7,  4'h0, 8'h05, 32'h00A5_A501, 32'h0},
    {4'd7,  4'h0, 8'h02, 32'h0000_0001, 32'h0},
    {4'd7,  4'h0, 8'h06, 32'h0, 32'h0},
    {4'd7,  4'h1, 8'h06, 32'h0, 32'hFFFF_0000},  // R7 write in between
    {4'd4,  4'h1, 8'h00, 32'h0, 32'h0000_FFF1},  // R4 driven levels
    {4'd7,  4'h0, 8'h05, 32'h00A5_A500, 32'h0},
    {4'd7,  4'h0, 8'h06, 32'h0, 32'h0},
    {4'd7,  4'h1, 8'h06, 32'h0, 32'hFFFF_0000},  // R7 wrong key
    {4'd7,  4'h0, 8'h05, 32'h00A5_A501, 32'h0},
    {4'd7,  4'h1, 8'h00, 32'h0, 32'h0000_FFF1},  // R7 read between
    {4'd7,  4'h0, 8'h06, 32'h0, 32'h0},
    {4'd7,  4'h1, 8'h06, 32'h0, 32'h0000_0000},  // R7 read did not disarm
    {4'd9,  4'h1, 8'h07, 32'h0, 32'h0000_0000},  // R9 unmapped
    {4'd9,  4'h1, 8'h02, 32'h0, 32'h0000_0000},  // R9 set strobe reads 0
    {4'd9,  4'h1, 8'h05, 32'h0, 32'h0000_0000},  // R9 key reads 0
    {4'd8,  4'h0, 8'h3F, 32'h0, 32'h0},
    {4'd2,  4'h1, 8'h3F, 32'h0, 32'h0000_0000},  // R2 R8 pin 31 unlocked now
    {4'd7,  4'h0, 8'h05, 32'h00A5_A501, 32'h0},
    {4'd7,  4'h0, 8'h05, 32'h00A5_A501, 32'h0},
    {4'd7,  4'h0, 8'h06, 32'hFFFF_FFFF, 32'h0}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             bus_wr = 1'b0;
  logic             bus_rd = 1'b0;
  logic [5:0]       bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic [NPINS-1:0] pad_in = '0;
  logic [NPINS-1:0] pad_out;
  logic [NPINS-1:0] pad_oe;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  gpio_lock_bank #(.NPINS(NPINS), .SYNC_STAGES(2)) u_gpio_lock_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 pad_out", 32'(pad_out), 32'h0);
    check("R1 pad_oe", 32'(pad_oe), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][75:72] == 4'h0) bus_write(VEC[i][69:64], VEC[i][63:32]);
      else begin
        bus_read(VEC[i][69:64], rv);
        check($sformatf("R%0d vector %0d", VEC[i][79:76], i), rv, VEC[i][31:0]);
      end
    end

    // R10 repeated key kept it armed, full lock landed
    bus_read(6'h06, rv);
    check("R10 lock after repeated key R7", rv, 32'hFFFF_FFFF);
    // R2 output enable for pins 3 and 31
    check("R2 pad_oe", 32'(pad_oe), 32'h8000_0008);
    // R4 pins match driven status
    check("R4 pad_out", 32'(pad_out), 32'h0000_FFF1);

    // R5 synchronizer latency
    @(negedge clk);
    pad_in = 32'hA5A5_0F0F;
    bus_read(6'h01, rv);
    check("R5 one edge too early", rv, 32'h0000_0000);
    bus_read(6'h01, rv);
    check("R5 after two edges", rv, 32'hA5A5_0F0F);

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 pad_out after reset", 32'(pad_out), 32'h0);
    check("R1 pad_oe after reset", 32'(pad_oe), 32'h0);
    bus_read(6'h06, rv);
    check("R1 lock after reset", rv, 32'hFFFF_FFFF);
    bus_read(6'h23, rv);
    check("R1 pin 3 input after reset", rv, 32'h1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end
endmodule